// File: doc/BRIEF.md
# Packed SIMD Arithmetic Right Shifter

This block shifts every lane of a packed vector right by one shared count. The vacated upper bits of each lane are filled with that lane's original sign bit. At run time a control bit sets the lanes to 16-bit words or 32-bit doublewords. A second control bit sets the active vector width to the full 128 bits or to the low 64 bits only.

The shift count comes from one of two places. It can be the low 64 bits of a second vector operand, read as an unsigned number. It can also be an 8-bit immediate, zero-extended. Any count at or above the lane width saturates, so each lane becomes copies of its sign bit. A large count never wraps to a small shift.

The result is registered. It appears one clock after an input strobe, together with a single-cycle valid pulse. The block changes no status flags and raises no exceptions.

Top module: `simd_sra_unit`

## Requirements
- R1: With `lane_dw`=0, each 16-bit lane of the result is that lane of `dst_vec` shifted right by the count (0..15). The freed upper bits are copies of the lane's original bit 15.
- R2: With `lane_dw`=1, each 32-bit lane of the result is that lane of `dst_vec` shifted right by the count (0..31). The freed upper bits are copies of the lane's original bit 31.
- R3: With 16-bit lanes, any count greater than 15 makes every result lane equal to 16 copies of its original sign bit.
- R4: With 32-bit lanes, any count greater than 31 makes every result lane equal to 32 copies of its original sign bit.
- R5: With `use_imm`=0, the count is all 64 bits of `cnt_vec` taken as unsigned. A set bit anywhere above the lane limit, including bit 63, forces saturation.
- R6: With `use_imm`=1, the count is `imm_cnt` zero-extended from 8 bits, and `cnt_vec` has no effect on the result.
- R7: With `wide`=0, result bits 127..64 are zero and the low 64 bits hold the shifted lanes. With `wide`=1, all 128 bits carry shifted lanes.
- R8: `out_valid` is high in the cycle after each cycle in which `in_valid` was sampled high, and low at all other times. `res_vec` is updated at the same edge.
- R9: Reset (active-low `rst_n`, asynchronous) clears `res_vec` and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are captured on this cycle |
| dst_vec | input | 128 | Packed vector to be shifted |
| cnt_vec | input | 64 | Low 64 bits of the count operand vector |
| imm_cnt | input | 8 | Immediate count |
| use_imm | input | 1 | 1 selects `imm_cnt`, 0 selects `cnt_vec` |
| lane_dw | input | 1 | 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| wide | input | 1 | 1 selects 128-bit width, 0 selects 64-bit width |
| res_vec | output | 128 | Registered shifted vector |
| out_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result, and its valid pulse, is due exactly one rising edge after the edge that samples `in_valid` high.

The bench drives each operation on a falling edge and holds the strobe for one cycle. It compares `res_vec` and `out_valid` on the next falling edge, midway between edges. It then waits one more falling edge to confirm that the strobe has dropped.

Reset is checked asynchronously, a nanosecond after `rst_n` falls, with no clock edge needed.

// File: rtl/sra_pkg.sv
package sra_pkg;
   typedef enum logic {
      LANE_16 = 1'b0,
      LANE_32 = 1'b1
   } lane_sel_e;

   localparam int unsigned WORD_W  = 16;
   localparam int unsigned DWORD_W = 32;
endpackage

// File: rtl/sra_count_sat.sv
module sra_count_sat #(
   parameter  int unsigned CNT_W  = 64,
   parameter  int unsigned LANE_W = 16,
   localparam int unsigned AW     = $clog2(LANE_W) + 1
) (
   input  logic [CNT_W-1:0] cnt,
   output logic [AW-1:0]    amt,
   output logic             sat
);
   if (LANE_W < 2 || (LANE_W & (LANE_W - 1)) != 0) begin : g_bad_lane
      $error("sra_count_sat: LANE_W must be a power of two");
   end
   if (CNT_W < AW) begin : g_bad_cnt
      $error("sra_count_sat: CNT_W too narrow for lane width");
   end

   // Full-width unsigned compare: no upper count bit is ever discarded.
   always_comb begin
      sat = (cnt > CNT_W'(LANE_W - 1));
      amt = sat ? AW'(LANE_W) : AW'(cnt[AW-2:0]);
   end
endmodule

// File: rtl/sra_lane.sv
module sra_lane #(
   parameter  int unsigned LANE_W = 16,
   localparam int unsigned AW     = $clog2(LANE_W) + 1
) (
   input  logic [LANE_W-1:0] din,
   input  logic [AW-1:0]     amt,
   output logic [LANE_W-1:0] dout
);
   // A shift amount equal to LANE_W yields a full sign fill.
   always_comb dout = LANE_W'($signed(din) >>> amt);
endmodule

// File: rtl/simd_sra_unit.sv
module simd_sra_unit #(
   parameter  int unsigned VEC_W = 128,
   parameter  int unsigned CNT_W = 64,
   parameter  int unsigned IMM_W = 8,
   localparam int unsigned HALF  = VEC_W / 2,
   localparam int unsigned NW    = VEC_W / sra_pkg::WORD_W,
   localparam int unsigned ND    = VEC_W / sra_pkg::DWORD_W,
   localparam int unsigned AWW   = $clog2(sra_pkg::WORD_W) + 1,
   localparam int unsigned AWD   = $clog2(sra_pkg::DWORD_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] dst_vec,
   input  logic [CNT_W-1:0] cnt_vec,
   input  logic [IMM_W-1:0] imm_cnt,
   input  logic             use_imm,
   input  logic             lane_dw,
   input  logic             wide,
   output logic [VEC_W-1:0] res_vec,
   output logic             out_valid
);
   import sra_pkg::*;

   if (VEC_W % (2 * DWORD_W) != 0) begin : g_bad_vec
      $error("simd_sra_unit: VEC_W must be a multiple of 64");
   end
   if (IMM_W > CNT_W) begin : g_bad_imm
      $error("simd_sra_unit: IMM_W must not exceed CNT_W");
   end

   logic [CNT_W-1:0] cnt_sel;
   logic [AWW-1:0]   amt_w;
   logic [AWD-1:0]   amt_d;
   logic             sat_w, sat_d;
   logic [VEC_W-1:0] word_res, dw_res, next_res;
   lane_sel_e        lane_sel;

   assign lane_sel = lane_sel_e'(lane_dw);
   assign cnt_sel  = use_imm ? CNT_W'(imm_cnt) : cnt_vec;

   sra_count_sat #(.CNT_W(CNT_W), .LANE_W(WORD_W)) u_sat_w (
      .cnt(cnt_sel), .amt(amt_w), .sat(sat_w));
   sra_count_sat #(.CNT_W(CNT_W), .LANE_W(DWORD_W)) u_sat_d (
      .cnt(cnt_sel), .amt(amt_d), .sat(sat_d));

   for (genvar g = 0; g < NW; g++) begin : g_word
      sra_lane #(.LANE_W(WORD_W)) u_lane (
         .din (dst_vec[g*WORD_W +: WORD_W]),
         .amt (amt_w),
         .dout(word_res[g*WORD_W +: WORD_W]));
   end

   for (genvar g = 0; g < ND; g++) begin : g_dword
      sra_lane #(.LANE_W(DWORD_W)) u_lane (
         .din (dst_vec[g*DWORD_W +: DWORD_W]),
         .amt (amt_d),
         .dout(dw_res[g*DWORD_W +: DWORD_W]));
   end

   always_comb begin
      next_res = (lane_sel == LANE_32) ? dw_res : word_res;
      if (!wide) next_res[VEC_W-1:HALF] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vec   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) res_vec <= next_res;
      end
   end

   // R8: strobe follows each accepted input by one cycle
   p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8: no strobe without an input one cycle earlier
   p_valid_needs_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   // R7: upper half is zero in narrow mode
   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!wide)) |-> (res_vec[VEC_W-1:HALF] == '0));

   for (genvar g = 0; g < NW; g++) begin : g_chk_w
      // R3: saturated word lanes are pure sign fill
      p_word_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(sat_w && !lane_dw)) |->
         (res_vec[g*WORD_W +: WORD_W] ==
          {WORD_W{res_vec[g*WORD_W + WORD_W - 1]}}));
   end
   for (genvar g = 0; g < ND; g++) begin : g_chk_d
      // R4: saturated doubleword lanes are pure sign fill
      p_dword_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(sat_d && lane_dw)) |->
         (res_vec[g*DWORD_W +: DWORD_W] ==
          {DWORD_W{res_vec[g*DWORD_W + DWORD_W - 1]}}));
   end
endmodule

// File: tb/test_simd_sra_unit.sv
module test_simd_sra_unit;
   localparam int VW = 128;
   localparam int CW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] dst_vec = '0;
   logic [CW-1:0] cnt_vec = '0;
   logic [7:0]    imm_cnt = '0;
   logic          use_imm = 1'b0, lane_dw = 1'b0, wide = 1'b1;
   logic [VW-1:0] res_vec;
   logic          out_valid;
   int            checks = 0, errors = 0;
   bit            done = 0;

   always #4 clk = ~clk;

   simd_sra_unit i_simd_sra_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_vec(dst_vec),
      .cnt_vec(cnt_vec), .imm_cnt(imm_cnt), .use_imm(use_imm),
      .lane_dw(lane_dw), .wide(wide), .res_vec(res_vec), .out_valid(out_valid));

   task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Bitwise reference: result bit b takes source bit b+eff, or the sign bit past the top.
   function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input logic [CW-1:0] c,
                                           input bit dw, input bit wd);
      logic [VW-1:0] r;
      int L, eff;
      r   = '0;
      L   = dw ? 32 : 16;
      eff = (c > 64'(L - 1)) ? L : int'(c[5:0]);
      for (int i = 0; i < VW / L; i++)
         for (int b = 0; b < L; b++) begin
            int s;
            s = b + eff;
            r[i*L + b] = (s < L) ? d[i*L + s] : d[i*L + L - 1];
         end
      if (!wd) r[VW-1:VW/2] = '0;
      return r;
   endfunction

   task automatic run(input logic [VW-1:0] d, input logic [CW-1:0] c, input logic [7:0] im,
                      input bit ui, input bit dw, input bit wd, input string tag);
      logic [VW-1:0] exp;
      @(negedge clk);
      dst_vec = d; cnt_vec = c; imm_cnt = im; use_imm = ui; lane_dw = dw; wide = wd;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp = model(d, ui ? {56'b0, im} : c, dw, wd);
      chk("R8 valid high", {127'b0, out_valid}, 128'd1);
      chk(tag, res_vec, exp);
      if (!wd) chk("R7 upper zero", {64'b0, res_vec[127:64]}, '0);
      @(negedge clk);
      chk("R8 valid drops", {127'b0, out_valid}, '0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] pats [4];
      logic [CW-1:0] cl [8];
      pats[0] = 128'h8000_7FFF_1234_F00D_0001_FFFF_A5A5_5A5A;
      pats[1] = 128'hFFFF_FFFF_8000_0000_7FFF_FFFF_0000_0001;
      pats[2] = 128'h0F0F_F0F0_C3C3_3C3C_9876_6789_DEAD_BEEF;
      pats[3] = 128'h7FFE_8001_4000_C000_2222_EEEE_0102_FEFD;

      // R9: reset state
      #1;
      chk("R9 reset res", res_vec, '0);
      chk("R9 reset valid", {127'b0, out_valid}, '0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      for (int dw = 0; dw < 2; dw++)
         for (int wd = 0; wd < 2; wd++)
            for (int p = 0; p < 4; p++) begin
               int L;
               L = dw ? 32 : 16;
               cl[0] = 0; cl[1] = 1; cl[2] = 64'(L - 1); cl[3] = 64'(L);
               cl[4] = 64'(L + 1); cl[5] = 255;
               cl[6] = 64'h0000_0001_0000_0000; cl[7] = 64'h8000_0000_0000_0000;
               for (int k = 0; k < 8; k++) begin
                  string tag;
                  if (k >= 6) tag = "R5 wide count";
                  else if (k <= 2) tag = dw ? "R2 dword shift" : "R1 word shift";
                  else tag = dw ? "R4 dword sat" : "R3 word sat";
                  run(pats[p], cl[k], 8'h00, 1'b0, dw[0], wd[0], tag);
               end
            end

      // R1 / R2: full count sweep in vector mode
      for (int dw = 0; dw < 2; dw++)
         for (int c = 0; c < 40; c++)
            run(pats[c % 4], 64'(c), 8'h00, 1'b0, dw[0], 1'b1, dw ? "R2 sweep" : "R1 sweep");

      // R6: immediate selected, vector count carries conflicting high bits
      for (int dw = 0; dw < 2; dw++)
         for (int c = 0; c < 36; c++)
            run(pats[(c + 1) % 4], 64'hFFFF_0000_0000_0003, 8'(c), 1'b1, dw[0], c[0], "R6 immediate");
      run(pats[0], 64'h0, 8'hFF, 1'b1, 1'b0, 1'b1, "R6 imm 255");
      run(pats[1], 64'h0, 8'h80, 1'b1, 1'b1, 1'b1, "R6 imm 128");

      // R9: asynchronous reset after activity
      run(pats[2], 64'd3, 8'h00, 1'b0, 1'b0, 1'b1, "R1 pre-reset");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 mid reset res", res_vec, '0);
      chk("R9 mid reset valid", {127'b0, out_valid}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      run(pats[3], 64'd5, 8'h00, 1'b0, 1'b1, 1'b0, "R2 after reset");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule